// File: doc/BRIEF.md
# Caller-ID Serial Byte Port

This block sits behind an FSK demodulator in a caller-identification receiver. It takes the demodulated 1200 baud asynchronous bit stream and a carrier-present qualifier, and hands the data to a microcontroller in one of two ways. The way is chosen by a mode input. With the mode input low, the bit stream goes straight to the serial data output, and the microcontroller does its own character framing in software. With the mode input high, the block does the framing itself. It waits for a start bit and confirms it, then assembles the eight data bits and the stop bit. Midway through the stop bit it loads all nine bits into a shift register and pulls an active-low ready flag.

The microcontroller answers the ready flag by pulsing a read clock. Each rising edge moves the next bit onto the data output, least significant data bit first. The ninth edge presents the received stop bit, so the software can detect a framing error. The ready flag clears on the first read edge. If no read edge comes, it clears after half a bit time. A power-down input holds both outputs high and clears all framing and readout state.

Bit timing comes from the system clock divided to sixteen ticks per bit. The read clock is asynchronous and is resynchronized before its edges are detected.

Top module: `cid_serial_port`

## Requirements
- R1: After reset, with the mode input high, `sdata` and `ready_n` are both high.
- R2: With `mode_sel` low, `pwr_down` low and `carrier_ok` high, `sdata` equals `rx_bit` combinationally.
- R3: With `mode_sel` low, `ready_n` stays high at all times. If `carrier_ok` is also low, `sdata` is held high whatever `rx_bit` is.
- R4: With `mode_sel` high, a character is one low start bit, eight data bits sent LSB first, and one stop bit. The start bit is dropped. The data and stop bits are loaded together, and `ready_n` falls midway through the stop bit: 9.5 bit times after the start edge, within one tick.
- R5: Each synchronized rising edge of `rd_clk` puts the next stored bit on `sdata`. Edges 1 to 8 give data bits 0 to 7, and edge 9 gives the received stop bit, whether it is 1 or 0.
- R6: A `rd_clk` rising edge that arrives while `ready_n` is low returns `ready_n` high, within the synchronizer latency, and also shifts out the first bit.
- R7: If no read edge arrives, `ready_n` stays low for half a bit time (OVERSAMPLE/2 ticks) and then returns high.
- R8: Read edges after the ninth bit are ignored, and `sdata` keeps showing the stop bit.
- R9: While `carrier_ok` is low in mode 1, no character is loaded. `ready_n` stays high, and unread bits of the previous character are still readable afterwards.
- R10: If `carrier_ok` drops in the middle of a character, that character is discarded and `ready_n` does not fall.
- R11: A low pulse on `rx_bit` shorter than half a bit is not confirmed as a start bit and loads nothing.
- R12: While `pwr_down` is high, `sdata` and `ready_n` are high in both modes. After power-down, the shift register is empty, so read edges do not change `sdata` (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, nominally 3.579545 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0: raw bit stream on `sdata`; 1: framed byte buffer |
| pwr_down | input | 1 | Power-down: outputs high, state cleared |
| carrier_ok | input | 1 | High while an FSK carrier is present |
| rx_bit | input | 1 | Demodulated bit stream, synchronous to `clk` |
| rd_clk | input | 1 | Asynchronous read clock from the microcontroller |
| sdata | output | 1 | Serial data output |
| ready_n | output | 1 | Active-low data-ready flag (mode 1) |

## Verification
The hardest case to reach from the ports is a read edge that lands inside the short window while `ready_n` is low. That window opens only partway through a stop bit, and its exact cycle depends on the phase of the tick divider. The bench drives each character one cycle at a time and watches `ready_n` on every cycle. As soon as it sees the fall, it raises `rd_clk` in the same cycle, then measures how long the flag took to clear and checks that the first data bit came out. A second hard case is a character that is lost while earlier bits are still unread. To reach it, the bench reads only part of a byte, sends a character with the carrier removed, and then reads the rest to show the old contents are still there.

// File: rtl/cid_pkg.sv
package cid_pkg;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_START = 2'd1,
      FR_DATA  = 2'd2,
      FR_STOP  = 2'd3
   } fr_state_t;

   // width able to hold values 0 .. n-1, never below one bit
   function automatic int unsigned cw(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cid_baud_tick.sv
module cid_baud_tick
   import cid_pkg::*;
#(
   parameter int unsigned DIV = 186
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int unsigned W = cw(DIV);
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == LAST) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/cid_sync.sv
module cid_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '0;
            else        ff <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '0;
            else        ff <= {ff[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = ff[STAGES-1];

endmodule

// File: rtl/cid_framer.sv
module cid_framer
   import cid_pkg::*;
#(
   parameter int unsigned OS = 16,
   parameter int unsigned DW = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        tick,
   input  logic        rx,
   input  logic        carrier,
   output logic        load,
   output logic [DW:0] word
);
   localparam int unsigned CW = cw(OS);
   localparam int unsigned IW = cw(DW);
   localparam logic [CW-1:0] MID_CNT  = CW'(OS / 2 - 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(OS - 1);
   localparam logic [IW-1:0] LAST_BIT = IW'(DW - 1);

   fr_state_t      state;
   logic [CW-1:0]  cnt;
   logic [IW-1:0]  idx;
   logic [DW-1:0]  shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= FR_IDLE;
         cnt   <= '0;
         idx   <= '0;
         shreg <= '0;
         word  <= '0;
         load  <= 1'b0;
      end else begin
         load <= 1'b0;
         if (clr || !carrier) begin
            state <= FR_IDLE;
            cnt   <= '0;
            idx   <= '0;
         end else if (tick) begin
            unique case (state)
               FR_IDLE: begin
                  if (!rx) begin
                     state <= FR_START;
                     cnt   <= '0;
                  end
               end
               FR_START: begin
                  if (cnt == MID_CNT) begin
                     cnt   <= '0;
                     idx   <= '0;
                     state <= rx ? FR_IDLE : FR_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FR_DATA: begin
                  if (cnt == LAST_CNT) begin
                     cnt   <= '0;
                     shreg <= {rx, shreg[DW-1:1]};
                     if (idx == LAST_BIT) begin
                        idx   <= '0;
                        state <= FR_STOP;
                     end else begin
                        idx <= idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FR_STOP: begin
                  if (cnt == LAST_CNT) begin
                     cnt   <= '0;
                     word  <= {rx, shreg};
                     load  <= 1'b1;
                     state <= FR_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= FR_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/cid_rd_shifter.sv
module cid_rd_shifter
   import cid_pkg::*;
#(
   parameter int unsigned DW   = 8,
   parameter int unsigned HALF = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        tick,
   input  logic        load,
   input  logic [DW:0] word,
   input  logic        rd_rise,
   output logic        out_bit,
   output logic        rdy_n
);
   localparam int unsigned LW = cw(DW + 2);
   localparam int unsigned TW = cw(HALF);
   localparam logic [LW-1:0] FULL     = LW'(DW + 1);
   localparam logic [TW-1:0] TLAST    = TW'(HALF - 1);

   logic [DW:0]   sreg;
   logic [LW-1:0] left;
   logic [TW-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg    <= '0;
         left    <= '0;
         tcnt    <= '0;
         out_bit <= 1'b1;
         rdy_n   <= 1'b1;
      end else if (clr) begin
         left    <= '0;
         tcnt    <= '0;
         out_bit <= 1'b1;
         rdy_n   <= 1'b1;
      end else if (load) begin
         sreg  <= word;
         left  <= FULL;
         tcnt  <= '0;
         rdy_n <= 1'b0;
      end else begin
         if (rd_rise && (left != '0)) begin
            out_bit <= sreg[0];
            sreg    <= {1'b0, sreg[DW:1]};
            left    <= left - 1'b1;
         end
         if (!rdy_n) begin
            if (rd_rise) begin
               rdy_n <= 1'b1;
            end else if (tick) begin
               if (tcnt == TLAST) rdy_n <= 1'b1;
               else               tcnt  <= tcnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cid_serial_port.sv
module cid_serial_port #(
   parameter int unsigned CLK_HZ      = 3579545,
   parameter int unsigned BAUD        = 1200,
   parameter int unsigned OVERSAMPLE  = 16,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_sel,
   input  logic pwr_down,
   input  logic carrier_ok,
   input  logic rx_bit,
   input  logic rd_clk,
   output logic sdata,
   output logic ready_n
);
   localparam int unsigned DIV  = CLK_HZ / (BAUD * OVERSAMPLE);
   localparam int unsigned HALF = OVERSAMPLE / 2;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("clock too slow for the requested baud and oversampling");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("oversampling must be even and at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_dw
         $error("at least two data bits are needed");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("synchronizer needs at least one stage");
      end
   endgenerate

   logic                 unit_clr;
   logic                 tick;
   logic                 rd_sync;
   logic                 rd_prev;
   logic                 rd_rise;
   logic                 load;
   logic [DATA_BITS:0]   word;
   logic                 out_bit;
   logic                 rdy_n_int;

   assign unit_clr = pwr_down | ~mode_sel;

   cid_baud_tick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (pwr_down),
      .tick (tick)
   );

   cid_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (rd_clk),
      .q    (rd_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_prev <= 1'b0;
      else        rd_prev <= rd_sync;
   end
   assign rd_rise = rd_sync & ~rd_prev;

   cid_framer #(.OS(OVERSAMPLE), .DW(DATA_BITS)) u_framer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (unit_clr),
      .tick   (tick),
      .rx     (rx_bit),
      .carrier(carrier_ok),
      .load   (load),
      .word   (word)
   );

   cid_rd_shifter #(.DW(DATA_BITS), .HALF(HALF)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (unit_clr),
      .tick   (tick),
      .load   (load),
      .word   (word),
      .rd_rise(rd_rise),
      .out_bit(out_bit),
      .rdy_n  (rdy_n_int)
   );

   always_comb begin
      if (pwr_down)      sdata = 1'b1;
      else if (mode_sel) sdata = out_bit;
      else               sdata = carrier_ok ? rx_bit : 1'b1;
   end

   assign ready_n = pwr_down | ~mode_sel | rdy_n_int;

endmodule

// File: rtl/cid_serial_port_chk.sv
module cid_serial_port_chk #(
   parameter int unsigned OS = 16
) (
   input logic clk,
   input logic rst_n,
   input logic mode_sel,
   input logic pwr_down,
   input logic carrier_ok,
   input logic sdata,
   input logic ready_n,
   input logic rd_rise,
   input logic tick
);
   logic [7:0] low_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_ticks <= '0;
      else if (ready_n)                 low_ticks <= '0;
      else if (tick && low_ticks != '1) low_ticks <= low_ticks + 1'b1;
   end

   p_pd_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> (sdata && ready_n));

   p_m0_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_down && !mode_sel && !carrier_ok) |-> sdata);

   p_m0_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_sel |-> ready_n);

   p_fall_carrier_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_n) |-> ($past(carrier_ok) && $past(mode_sel)));

   p_ready_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_n |-> (low_ticks <= 8'(OS / 2)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel && !pwr_down && $past(mode_sel) && !$past(pwr_down) && !$past(rd_rise))
         |-> $stable(sdata));

endmodule

bind cid_serial_port cid_serial_port_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_sel  (mode_sel),
   .pwr_down  (pwr_down),
   .carrier_ok(carrier_ok),
   .sdata     (sdata),
   .ready_n   (ready_n),
   .rd_rise   (rd_rise),
   .tick      (tick)
);

// File: tb/cid_serial_port_tb_top.sv
module cid_serial_port_tb_top;
   localparam int unsigned TB_CLK_HZ = 76800;   // 4 clocks per tick
   localparam int BITC = 64;                     // clocks per bit

   logic clk = 1'b0;
   logic rst_n, mode_sel, pwr_down, carrier_ok, rx_bit, rd_clk;
   logic sdata, ready_n;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic exp_q[$];
   logic last_bit = 1'b1;

   always #10 clk = ~clk;

   cid_serial_port #(.CLK_HZ(TB_CLK_HZ)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pwr_down(pwr_down),
      .carrier_ok(carrier_ok), .rx_bit(rx_bit), .rd_clk(rd_clk),
      .sdata(sdata), .ready_n(ready_n)
   );

   task automatic check_bit(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic check_rng(string req, int act, int lo, int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor side of the scoreboard: one read pulse, pop and compare
   task automatic read_bits(int n, string req);
      for (int k = 0; k < n; k++) begin
         logic e;
         @(negedge clk) rd_clk = 1'b1;
         wait_cyc(4);
         rd_clk = 1'b0;
         wait_cyc(4);
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            last_bit = e;
         end else begin
            e = last_bit;
         end
         check_bit(req, sdata, e);
      end
   endtask

   // driver side: sends one character, pushes expected bits when a load is due
   task automatic send_char(logic [7:0] b, logic stop, bit expect_load,
                            bit early_read, bit drop_mid, string req);
      logic fb[0:10];
      int fall = -1;
      int rise = -1;
      int rdc  = -1;
      int cyc  = 0;
      fb[0] = 1'b0;
      for (int k = 0; k < 8; k++) fb[k+1] = b[k];
      fb[9]  = stop;
      fb[10] = 1'b1;
      for (int i = 0; i < 11; i++) begin
         for (int c = 0; c < BITC; c++) begin
            @(negedge clk);
            if (fall < 0 && ready_n === 1'b0) fall = cyc;
            if (fall >= 0 && rise < 0 && ready_n === 1'b1) rise = cyc;
            if (c == 0) rx_bit = fb[i];
            if (drop_mid && i == 4 && c == 0) carrier_ok = 1'b0;
            if (early_read && fall >= 0 && rdc < 0) begin
               rd_clk = 1'b1;
               rdc = cyc;
            end
            if (rdc >= 0 && cyc == rdc + 4) rd_clk = 1'b0;
            cyc++;
         end
      end
      wait_cyc(40);
      if (expect_load) begin
         check_rng({req, " R4 ready fall at mid stop bit"}, fall, 604, 618);
         for (int k = 0; k < 8; k++) exp_q.push_back(b[k]);
         exp_q.push_back(stop);
         if (early_read) begin
            check_rng("R6 ready cleared by first read edge", rise - rdc, 2, 5);
            last_bit = exp_q.pop_front();
            check_bit("R6 first bit out by clearing edge", sdata, last_bit);
         end else begin
            check_rng("R7 ready low for half a bit", rise - fall, 29, 34);
         end
      end else begin
         check_rng({req, " no load, ready stays high"}, fall, -1, -1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired (all requirements)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; mode_sel = 1'b1; pwr_down = 1'b0; carrier_ok = 1'b1;
      rx_bit = 1'b1; rd_clk = 1'b0;
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      check_bit("R1 reset sdata", sdata, 1'b1);
      check_bit("R1 reset ready_n", ready_n, 1'b1);

      // normal character, timeout clear, full readout, extra edges
      send_char(8'hA5, 1'b1, 1, 0, 0, "R4");
      read_bits(9, "R5 LSB first then stop bit");
      read_bits(3, "R8 extra read edges ignored");

      // early read clears ready; stop bit of 0 is readable
      send_char(8'h3C, 1'b0, 1, 1, 0, "R4");
      read_bits(8, "R5 remaining bits, stop bit 0");
      read_bits(2, "R8 extra read edges ignored");

      // partial read, then a character without carrier
      send_char(8'h96, 1'b1, 1, 0, 0, "R4");
      read_bits(4, "R5 first half of byte");
      carrier_ok = 1'b0;
      send_char(8'h0F, 1'b1, 0, 0, 0, "R9");
      carrier_ok = 1'b1;
      wait_cyc(10);
      read_bits(5, "R9 old contents kept without carrier");

      // carrier lost mid-frame
      send_char(8'h55, 1'b1, 0, 0, 1, "R10");
      carrier_ok = 1'b1;
      wait_cyc(10);
      read_bits(1, "R10 no new contents");

      // short start glitch
      begin
         int seen = 0;
         @(negedge clk) rx_bit = 1'b0;
         wait_cyc(16);
         rx_bit = 1'b1;
         for (int c = 0; c < 700; c++) begin
            @(negedge clk);
            if (ready_n === 1'b0) seen++;
         end
         check_rng("R11 glitch not taken as start", seen, 0, 0);
      end
      send_char(8'hC3, 1'b1, 1, 0, 0, "R11 recovery");
      read_bits(9, "R5 after glitch");

      // power-down
      send_char(8'h7E, 1'b1, 1, 0, 0, "R4");
      read_bits(1, "R5 bit0 low before power-down");
      pwr_down = 1'b1;
      wait_cyc(2);
      check_bit("R12 sdata high in power-down", sdata, 1'b1);
      check_bit("R12 ready_n high in power-down", ready_n, 1'b1);
      mode_sel = 1'b0;
      rx_bit = 1'b0;
      wait_cyc(1);
      check_bit("R12 mode 0 sdata high in power-down", sdata, 1'b1);
      rx_bit = 1'b1;
      mode_sel = 1'b1;
      wait_cyc(2);
      pwr_down = 1'b0;
      exp_q.delete();
      last_bit = 1'b1;
      wait_cyc(4);
      read_bits(2, "R12 register empty after power-down");

      // mode 0 passthrough
      mode_sel = 1'b0;
      carrier_ok = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk) rx_bit = (k == 1 || k == 2);
         #1;
         check_bit("R2 mode 0 passthrough", sdata, rx_bit);
         check_bit("R3 mode 0 ready high", ready_n, 1'b1);
      end
      send_char(8'h81, 1'b1, 0, 0, 0, "R3 mode 0");
      carrier_ok = 1'b0;
      @(negedge clk) rx_bit = 1'b0;
      #1;
      check_bit("R3 mode 0 no carrier forces high", sdata, 1'b1);
      rx_bit = 1'b1;
      carrier_ok = 1'b1;
      wait_cyc(4);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule